// File: doc/BRIEF.md
# Test Pattern Source with Control Registers

This block is a streaming stimulus source for exercising a datapath or serial link. Software programs it through a small bank of 32-bit registers. A control word holds three bits: run, pattern choice and hold-constant. A second word holds a start value. The block then presents one data word per cycle on a valid/ready interface. The words come from a maximal-length pseudo-random shift register, from an incrementing counter, or are a fixed copy of the start value.

A third, read-only word counts the words the downstream side has accepted since the run bit was last set. Software can poll this count to confirm that traffic is flowing. Register reads return data on the clock after the request. Several copies of the block can share one address space by giving each copy a base of its index shifted left by `ADDR_W`; that decoding sits outside this block.

Top module: `tpg_top`

## Requirements
- R1: A synchronous reset clears all registers. After reset `out_valid` is 0, `out_data` is 0 and `reg_rdata` is 0.
- R2: Word 0 is the control register. All 32 bits are read/write and read back exactly as written. Bit 0 is run. Bit 1 selects the pattern: 0 is pseudo-random and 1 is counter. Bit 2 is hold-constant.
- R3: Word 1 is the read/write start value. Writes to word 2 and word 3 change nothing. Word 3 reads as 0.
- R4: `reg_rdata` takes the addressed register's value on the clock edge that samples `reg_rd`. If a write lands in the same cycle, the value returned is the one from before the write. When `reg_rd` is low, `reg_rdata` holds its value.
- R5: When run is 1 and the block is idle, the next edge sets `out_valid`. On that edge `out_data` loads the start value; in pseudo-random mode a start value of 0 is replaced by all ones. When run is 0, the next edge clears `out_valid` and `out_data` to 0.
- R6: In pseudo-random mode an accepted word d is followed by {d[30:0], d[31]^d[21]^d[1]^d[0]} (32-bit data). If d is 0, the next word is all ones instead.
- R7: In counter mode an accepted word d is followed by d+1 modulo 2^32. A change of pattern select during a run continues from the current word.
- R8: The pattern advances only on a cycle where `out_valid` and `out_ready` are both 1. Otherwise `out_data` holds its value.
- R9: While hold-constant is 1 during a run, `out_data` equals the word 1 value from the previous cycle, whether or not a transfer is accepted.
- R10: Word 2 reads the accepted-word count, zero-extended to 32 bits. The count is 0 while `out_valid` is 0. It rises by one per accepted word and stops at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | A pattern word is present |
| out_data | output | DATA_W | Pattern word |

## Verification
The hardest state to reach from the ports is a saturated sent-word count at 32-bit width. The bench therefore builds the block with an 8-bit count and holds ready high for several hundred cycles. It then reads word 2 to confirm the count has stopped at 255.

A second corner is counter mode parked at 0 and then switched to pseudo-random mode mid-run. The bench reaches it with a zero start value, ready held low, and then a select change. The bench also stalls ready while it changes the mode and the start value, so that holding and reloading are exercised separately.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int BUS_W = 32;

    // Feedback tap mask of a maximal-length Fibonacci LFSR, bit k = stage k+1
    function automatic logic [63:0] lfsr_taps(input int width);
        logic [63:0] m;
        m = '0;
        case (width)
            8:       begin m[7]  = 1'b1; m[5]  = 1'b1; m[4]  = 1'b1; m[3]  = 1'b1; end
            16:      begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3]  = 1'b1; end
            24:      begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
            default: begin m[31] = 1'b1; m[21] = 1'b1; m[1]  = 1'b1; m[0]  = 1'b1; end
        endcase
        return m;
    endfunction

    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic [BUS_W-1:0] seed;
        logic [BUS_W-1:0] rdata;
    } reg_state_t;

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs #(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [tpg_pkg::BUS_W-1:0] reg_wdata,
    output logic [tpg_pkg::BUS_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]          sent_cnt,
    output logic                      ctrl_en,
    output logic                      ctrl_sel,
    output logic                      ctrl_const,
    output logic [tpg_pkg::BUS_W-1:0] seed_word
);
    import tpg_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(2);

    reg_state_t r_d, r_q;
    logic [BUS_W-1:0] rd_mux;

    always_comb begin
        case (reg_addr)
            A_CTRL:  rd_mux = r_q.ctrl;
            A_SEED:  rd_mux = r_q.seed;
            A_CNT:   rd_mux = BUS_W'(sent_cnt);
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (reg_rd) begin
            r_d.rdata = rd_mux;
        end
        if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                r_d.ctrl = reg_wdata;
            end
            if (reg_addr == A_SEED) begin
                r_d.seed = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata  = r_q.rdata;
    assign ctrl_en    = r_q.ctrl[0];
    assign ctrl_sel   = r_q.ctrl[1];
    assign ctrl_const = r_q.ctrl[2];
    assign seed_word  = r_q.seed;

endmodule

// File: rtl/tpg_engine.sv
module tpg_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_en,
    input  logic              ctrl_sel,
    input  logic              ctrl_const,
    input  logic [DATA_W-1:0] seed,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              fire
);
    localparam logic [63:0] TAPS64 = tpg_pkg::lfsr_taps(DATA_W);
    localparam logic [DATA_W-1:0] TAPS = TAPS64[DATA_W-1:0];

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t e_d, e_q;
    logic [DATA_W-1:0] prbs_next;
    logic [DATA_W-1:0] cnt_next;
    logic [DATA_W-1:0] load_val;

    always_comb begin
        if (e_q.data == '0) begin
            prbs_next = '1;
        end else begin
            prbs_next = {e_q.data[DATA_W-2:0], ^(e_q.data & TAPS)};
        end
        cnt_next = e_q.data + DATA_W'(1);
        if (!ctrl_const && !ctrl_sel && seed == '0) begin
            load_val = '1;
        end else begin
            load_val = seed;
        end
    end

    assign fire = e_q.active && out_ready;

    always_comb begin
        e_d = e_q;
        if (!ctrl_en) begin
            e_d.active = 1'b0;
            e_d.data   = '0;
        end else if (!e_q.active) begin
            e_d.active = 1'b1;
            e_d.data   = load_val;
        end else if (ctrl_const) begin
            e_d.data   = seed;
        end else if (fire) begin
            e_d.data   = ctrl_sel ? cnt_next : prbs_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign out_valid = e_q.active;
    assign out_data  = e_q.data;

endmodule

// File: rtl/tpg_counter.sv
module tpg_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             fire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!active) begin
            c_d.cnt = '0;
        end else if (fire && c_q.cnt != CNT_MAX) begin
            c_d.cnt = c_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.cnt;

endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic              ctrl_en;
    logic              ctrl_sel;
    logic              ctrl_const;
    logic [31:0]       seed_word;
    logic [DATA_W-1:0] seed_trim;
    logic [CNT_W-1:0]  sent_cnt;
    logic              fire;

    assign seed_trim = seed_word[DATA_W-1:0];

    tpg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sent_cnt   (sent_cnt),
        .ctrl_en    (ctrl_en),
        .ctrl_sel   (ctrl_sel),
        .ctrl_const (ctrl_const),
        .seed_word  (seed_word)
    );

    tpg_engine #(.DATA_W(DATA_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ctrl_en    (ctrl_en),
        .ctrl_sel   (ctrl_sel),
        .ctrl_const (ctrl_const),
        .seed       (seed_trim),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .fire       (fire)
    );

    tpg_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .active (out_valid),
        .fire   (fire),
        .count  (sent_cnt)
    );

endmodule

// File: rtl/tpg_top_chk.sv
module tpg_top_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              ctrl_en,
    input logic              ctrl_const,
    input logic [DATA_W-1:0] seed_trim,
    input logic [CNT_W-1:0]  sent_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R5: run cleared stops the stream on the next edge
    a_r5_stop: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (!out_valid && out_data == '0));

    // R5: run set while idle starts the stream on the next edge
    a_r5_start: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !out_valid) |=> out_valid);

    // R8: a stalled word holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && ctrl_en && !ctrl_const) |=> $stable(out_data));

    // R9: hold-constant copies the start value
    a_r9_const: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ctrl_en && ctrl_const) |=> out_data == $past(seed_trim));

    // R10: one step per accepted word
    a_r10_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && sent_cnt != CNT_MAX) |=> sent_cnt == $past(sent_cnt) + CNT_W'(1));

    // R10: saturation holds
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sent_cnt == CNT_MAX) |=> sent_cnt == CNT_MAX);

    // R10: idle clears the count
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> sent_cnt == '0);

endmodule

bind tpg_top tpg_top_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .ctrl_en    (ctrl_en),
    .ctrl_const (ctrl_const),
    .seed_trim  (seed_trim),
    .sent_cnt   (sent_cnt)
);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
    localparam int CNT_W = 8;
    localparam logic [31:0] CMAX = 32'(2**CNT_W - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    always #2 clk = ~clk;

    tpg_top #(.DATA_W(32), .CNT_W(CNT_W), .ADDR_W(2)) dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R1";
    logic [31:0] lcg = 32'h1ace_b00c;

    // behavioural reference state
    logic [31:0] m_ctrl = '0, m_seed = '0, m_rdata = '0, m_cnt = '0, m_data = '0;
    logic        m_act = 1'b0;

    function automatic logic [31:0] prbs(input logic [31:0] v);
        if (v == 0) return '1;
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        logic [31:0] n_ctrl, n_seed, n_rdata, n_cnt, n_data;
        logic        n_act, hs;
        n_ctrl = m_ctrl; n_seed = m_seed; n_rdata = m_rdata;
        n_cnt = m_cnt; n_data = m_data; n_act = m_act;
        if (rst) begin
            n_ctrl = 0; n_seed = 0; n_rdata = 0; n_cnt = 0; n_data = 0; n_act = 0;
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: n_rdata = m_ctrl;
                    2'd1: n_rdata = m_seed;
                    2'd2: n_rdata = m_cnt;
                    default: n_rdata = 0;
                endcase
            end
            hs = m_act && out_ready;
            if (!m_act) n_cnt = 0;
            else if (hs && m_cnt != CMAX) n_cnt = m_cnt + 1;
            if (!m_ctrl[0]) begin
                n_act = 0; n_data = 0;
            end else if (!m_act) begin
                n_act = 1;
                n_data = (!m_ctrl[2] && !m_ctrl[1] && m_seed == 0) ? 32'hffff_ffff : m_seed;
            end else if (m_ctrl[2]) begin
                n_data = m_seed;
            end else if (hs) begin
                n_data = m_ctrl[1] ? m_data + 1 : prbs(m_data);
            end
            if (reg_wr && reg_addr == 2'd0) n_ctrl = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) n_seed = reg_wdata;
        end
        @(posedge clk);
        #1;
        m_ctrl = n_ctrl; m_seed = n_seed; m_rdata = n_rdata;
        m_cnt = n_cnt; m_data = n_data; m_act = n_act;
        check("out_valid", 32'(out_valid), 32'(m_act));
        check("out_data", out_data, m_data);
        check("reg_rdata", reg_rdata, m_rdata);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a);
        reg_rd = 1'b1; reg_addr = a;
        cycle();
        reg_rd = 1'b0;
    endtask

    // mode 0: ready low, 1: ready high, 2: pseudo-random ready
    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            out_ready = (mode == 2) ? lcg[17] : (mode == 1);
            cycle();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        run(3, 0);
        rst = 1'b0;
        rd_reg(2'd0); rd_reg(2'd1); rd_reg(2'd2);

        tag = "R2";
        wr_reg(2'd0, 32'ha5a5_f0f8);
        rd_reg(2'd0);
        run(3, 1);

        tag = "R5";
        wr_reg(2'd1, 32'h1234_5678);
        wr_reg(2'd0, 32'h0000_0001);
        run(3, 0);
        tag = "R6";
        run(40, 2);
        rd_reg(2'd2);
        tag = "R8";
        run(10, 0);
        rd_reg(2'd2);

        tag = "R7";
        wr_reg(2'd0, 32'h3);
        run(30, 2);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'hffff_fffd);
        wr_reg(2'd0, 32'h3);
        run(10, 1);

        tag = "R9";
        wr_reg(2'd0, 32'h7);
        run(5, 0);
        wr_reg(2'd1, 32'hdead_beef);
        run(6, 2);
        rd_reg(2'd2);

        tag = "R6";
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'h1);
        run(20, 1);
        wr_reg(2'd0, 32'h0);
        out_ready = 1'b0;
        wr_reg(2'd0, 32'h3);
        run(3, 0);
        wr_reg(2'd0, 32'h1);
        run(5, 1);

        tag = "R10";
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd0, 32'h1);
        run(300, 1);
        rd_reg(2'd2);
        run(5, 1);
        rd_reg(2'd2);
        wr_reg(2'd0, 32'h0);
        run(2, 0);
        rd_reg(2'd2);

        tag = "R3";
        wr_reg(2'd2, 32'hffff_ffff);
        wr_reg(2'd3, 32'hffff_ffff);
        rd_reg(2'd2); rd_reg(2'd3); rd_reg(2'd1); rd_reg(2'd0);

        tag = "R4";
        rd_reg(2'd1);
        run(4, 1);
        wr_reg(2'd1, 32'h0bad_cafe);
        run(2, 1);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h5555_aaaa;
        cycle();
        reg_wr = 1'b0; reg_rd = 1'b0;
        rd_reg(2'd1);
        run(2, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule